// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Up Counter

A small up counter that steps on the rising clock edge. One parameter makes it a decade counter (0 to 9) or a full binary counter (0 to 2^WIDTH-1). A second parameter makes the active-low clear either synchronous (sampled at the clock edge) or asynchronous (acting at once, with no clock needed). An active-low parallel load copies the data input into the count at the next edge. Two count enables, P and T, must both be high for the count to advance.

Enable T also gates a look-ahead carry. The carry is high while the count sits at its terminal value and T is high. It is combinational, so it is valid in the same cycle. To build a wider counter, the carry of one stage drives the T enable of the next stage, and P is shared across all stages. All stages run from one clock, and no extra gating is needed between them.

Top module: `casc_counter`

## Requirements
- R1: With SYNC clear selected (ASYNC_CLR=0), clr_n low at a rising edge makes q zero after that edge. This overrides both load and count.
- R2: With ASYNC_CLR=1, q becomes zero as soon as clr_n goes low, with no clock edge needed. It stays zero while clr_n is low, even when load is requested.
- R3: When clr_n is high and load_n is low, q takes din at the next rising edge, whatever the levels of en_p and en_t.
- R4: When clr_n and load_n are high and en_p and en_t are both high, q increases by one at the rising edge.
- R5: When clr_n and load_n are high and either en_p or en_t is low, q keeps its value across the edge.
- R6: In decade mode (DECADE=1), counting from 9 gives 0.
- R7: In decade mode, counting from any value 10 to 15 gives 0 in one step. The carry stays low at those values.
- R8: In binary mode (DECADE=0), counting from all ones gives 0.
- R9: carry is 1 exactly when en_t is 1 and q equals the terminal value (9 for decade, all ones for binary). It follows q and en_t in the same cycle and does not depend on en_p.
- R10: Two binary stages share clk, clr_n, load_n and en_p, and the low stage's carry drives the high stage's en_t. The pair then counts as one 8-bit counter, including 0x0F to 0x10 and 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; synchronous or asynchronous by parameter |
| load_n | input | 1 | Active-low parallel load |
| din | input | WIDTH | Value loaded into the count |
| en_p | input | 1 | Count enable (count path only) |
| en_t | input | 1 | Count enable that also gates carry |
| q | output | WIDTH | Current count |
| carry | output | 1 | Look-ahead carry to next stage's en_t |

## Verification
The hardest situation to reach is a decade counter holding a value from 10 to 15. Normal counting never produces one. The stimulus therefore loads 12 and 15 directly, checks that the carry stays low with T high, and then counts once to see the counter fall back to zero.

The second hard case is the carry ripple across two stages at 0x0F and 0xFF. The bench reaches it quickly by preloading the cascade one or two counts below each boundary.

The asynchronous clear is checked by dropping clr_n in the middle of a cycle, with a load also pending, and sampling q before the next edge arrives.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } ctr_act_e;

    typedef struct packed {
        logic clear;
        logic load;
        logic step;
    } ctr_req_t;

    function automatic int unsigned term_value(input bit decade, input int unsigned width);
        if (decade) return 9;
        return (1 << width) - 1;
    endfunction

endpackage

// File: rtl/ctr_arbiter.sv
module ctr_arbiter
    import ctr_pkg::*;
(
    input  ctr_req_t req,
    output ctr_act_e act
);
    always_comb begin
        if (req.clear)      act = ACT_CLEAR;
        else if (req.load)  act = ACT_LOAD;
        else if (req.step)  act = ACT_COUNT;
        else                act = ACT_HOLD;
    end
endmodule

// File: rtl/ctr_step.sv
module ctr_step #(
    parameter int unsigned WIDTH  = 4,
    parameter bit          DECADE = 1'b1
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] inc,
    output logic             at_term
);
    localparam logic [WIDTH-1:0] TERM = WIDTH'(ctr_pkg::term_value(DECADE, WIDTH));

    generate
        if (DECADE) begin : g_dec
            always_comb inc = (cur >= TERM) ? '0 : cur + WIDTH'(1);
        end else begin : g_bin
            always_comb inc = cur + WIDTH'(1);
        end
    endgenerate

    assign at_term = (cur == TERM);
endmodule

// File: rtl/ctr_carry.sv
module ctr_carry (
    input  logic at_term,
    input  logic en_t,
    output logic carry
);
    assign carry = at_term & en_t;
endmodule

// File: rtl/casc_counter.sv
module casc_counter
    import ctr_pkg::*;
#(
    parameter int unsigned WIDTH     = 4,
    parameter bit          DECADE    = 1'b1,
    parameter bit          ASYNC_CLR = 1'b0
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_p,
    input  logic             en_t,
    output logic [WIDTH-1:0] q,
    output logic             carry
);
    localparam logic [WIDTH-1:0] TERM = WIDTH'(term_value(DECADE, WIDTH));

    logic [WIDTH-1:0] cnt;
    logic [WIDTH-1:0] cnt_inc;
    logic [WIDTH-1:0] cnt_next;
    logic             at_term;
    ctr_req_t         req;
    ctr_act_e         act;

    assign req.clear = ASYNC_CLR ? 1'b0 : ~clr_n;
    assign req.load  = ~load_n;
    assign req.step  = en_p & en_t;

    ctr_arbiter u_arb (.req(req), .act(act));

    ctr_step #(.WIDTH(WIDTH), .DECADE(DECADE)) u_step (
        .cur(cnt), .inc(cnt_inc), .at_term(at_term)
    );

    ctr_carry u_carry (.at_term(at_term), .en_t(en_t), .carry(carry));

    always_comb begin
        case (act)
            ACT_CLEAR: cnt_next = '0;
            ACT_LOAD:  cnt_next = din;
            ACT_COUNT: cnt_next = cnt_inc;
            default:   cnt_next = cnt;
        endcase
    end

    generate
        if (ASYNC_CLR) begin : g_aclr
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) cnt <= '0;
                else        cnt <= cnt_next;
            end
            AST_ASYNC_CLEAR: assert property (@(posedge clk) !clr_n |-> q == '0); // R2
        end else begin : g_sclr
            always_ff @(posedge clk) cnt <= cnt_next;
            AST_SYNC_CLEAR: assert property (@(posedge clk) !clr_n |=> q == '0); // R1
        end
    endgenerate

    assign q = cnt;

    AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> q == $past(din)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t && q < TERM) |=> q == $past(q) + WIDTH'(1)); // R4
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_p && en_t)) |=> $stable(q)); // R5
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t && q >= TERM) |=> q == '0); // R7
    AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!clr_n)
        carry |-> (en_t && q == TERM)); // R9
endmodule

// File: tb/sim_casc_counter.sv
module sim_casc_counter;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    // single decade stage, synchronous clear
    logic       d_clr_n = 1'b0, d_load_n = 1'b1, d_p = 1'b0, d_t = 1'b0;
    logic [3:0] d_din = '0;
    logic [3:0] d_q;
    logic       d_c;

    casc_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b0)) u0 (
        .clk(clk), .clr_n(d_clr_n), .load_n(d_load_n), .din(d_din),
        .en_p(d_p), .en_t(d_t), .q(d_q), .carry(d_c)
    );

    // two binary stages, asynchronous clear
    logic       c_clr_n = 1'b0, c_load_n = 1'b1, c_p = 1'b0, c_t = 1'b0;
    logic [7:0] c_din = '0;
    logic [3:0] lo_q, hi_q;
    logic       lo_c, hi_c;

    casc_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) u_lo (
        .clk(clk), .clr_n(c_clr_n), .load_n(c_load_n), .din(c_din[3:0]),
        .en_p(c_p), .en_t(c_t), .q(lo_q), .carry(lo_c)
    );
    casc_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b1)) u_hi (
        .clk(clk), .clr_n(c_clr_n), .load_n(c_load_n), .din(c_din[7:4]),
        .en_p(c_p), .en_t(lo_c), .q(hi_q), .carry(hi_c)
    );

    typedef struct {
        bit         unit;
        logic [7:0] q;
        logic [1:0] c;
        string      tag;
    } item_t;

    item_t sbq[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    logic [3:0] m_dec = '0;
    logic [7:0] m_cas = '0;

    task automatic check(input bit ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expectations half a cycle after each edge
    initial begin
        forever begin
            @(negedge clk);
            if (sbq.size() > 0) begin
                item_t it;
                logic [9:0] a;
                logic [9:0] e;
                it = sbq.pop_front();
                if (it.unit == 1'b0) a = {2'b0, d_c, 3'b0, d_q};
                else                 a = {hi_c, lo_c, hi_q, lo_q};
                if (it.unit == 1'b0) e = {2'b0, it.c[0], 3'b0, it.q[3:0]};
                else                 e = {it.c, it.q};
                check(a === e, it.tag, a, e);
            end
        end
    end

    task automatic drv_dec(input logic clr_n, input logic ld_n, input logic [3:0] d,
                           input logic p, input logic t, input string tag);
        item_t it;
        @(negedge clk);
        #2;
        d_clr_n = clr_n; d_load_n = ld_n; d_din = d; d_p = p; d_t = t;
        if (!clr_n)      m_dec = '0;
        else if (!ld_n)  m_dec = d;
        else if (p && t) m_dec = (m_dec >= 4'd9) ? 4'd0 : m_dec + 4'd1;
        @(posedge clk);
        it.unit = 1'b0; it.q = {4'b0, m_dec}; it.c = {1'b0, t && m_dec == 4'd9}; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic drv_cas(input logic clr_n, input logic ld_n, input logic [7:0] d,
                           input logic p, input logic t, input string tag);
        item_t it;
        logic  lc;
        @(negedge clk);
        #2;
        c_clr_n = clr_n; c_load_n = ld_n; c_din = d; c_p = p; c_t = t;
        if (!clr_n)      m_cas = '0;
        else if (!ld_n)  m_cas = d;
        else if (p && t) m_cas = m_cas + 8'd1;
        @(posedge clk);
        lc = t && m_cas[3:0] == 4'hF;
        it.unit = 1'b1; it.q = m_cas; it.c = {lc && m_cas[7:4] == 4'hF, lc}; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic async_clear_cas();
        item_t it;
        @(negedge clk);
        #2;
        c_clr_n = 1'b0; c_load_n = 1'b0; c_din = 8'h55; c_p = 1'b1; c_t = 1'b1;
        #1;
        check({hi_q, lo_q} === 8'h00, "R2 immediate", {2'b0, hi_q, lo_q}, 10'h0);
        m_cas = '0;
        @(posedge clk);
        it.unit = 1'b1; it.q = 8'h00; it.c = 2'b00; it.tag = "R2 held";
        sbq.push_back(it);
    endtask

    initial begin
        // decade stage, synchronous clear
        drv_dec(0, 1, 4'd0, 0, 0, "R1 reset");
        drv_dec(0, 1, 4'd0, 1, 1, "R1 reset");
        drv_dec(1, 0, 4'd7, 0, 0, "R3 load idle");
        drv_dec(1, 1, 4'd0, 1, 1, "R4 count");
        drv_dec(1, 1, 4'd0, 1, 1, "R9 carry at 9");
        drv_dec(1, 1, 4'd0, 0, 1, "R5 hold P low, R9 carry");
        drv_dec(1, 1, 4'd0, 1, 0, "R5 hold T low, R9 no carry");
        drv_dec(1, 1, 4'd0, 1, 1, "R6 wrap 9->0");
        for (int i = 0; i < 5; i++) drv_dec(1, 1, 4'd0, 1, 1, "R4 count run");
        drv_dec(0, 0, 4'd3, 1, 1, "R1 clear over load");
        drv_dec(1, 1, 4'd0, 1, 1, "R4 count");
        drv_dec(1, 0, 4'd6, 1, 1, "R3 load while counting");
        drv_dec(1, 0, 4'd12, 0, 1, "R7 illegal no carry");
        drv_dec(1, 1, 4'd0, 1, 1, "R7 recover 12");
        drv_dec(1, 0, 4'd15, 0, 1, "R7 illegal 15");
        drv_dec(1, 1, 4'd0, 1, 1, "R7 recover 15");
        drv_dec(1, 1, 4'd0, 1, 1, "R4 count");

        // binary cascade, asynchronous clear
        drv_cas(0, 1, 8'h00, 0, 0, "R2 reset");
        drv_cas(1, 0, 8'h0E, 0, 0, "R3 cascade load");
        drv_cas(1, 1, 8'h00, 1, 1, "R9 lo carry");
        drv_cas(1, 1, 8'h00, 1, 1, "R10 ripple 0F->10");
        drv_cas(1, 0, 8'hFE, 1, 1, "R3 cascade load");
        drv_cas(1, 1, 8'h00, 1, 1, "R9 hi carry");
        drv_cas(1, 1, 8'h00, 0, 1, "R5 cascade hold");
        drv_cas(1, 1, 8'h00, 1, 1, "R8 R10 wrap FF->00");
        for (int i = 0; i < 20; i++) drv_cas(1, 1, 8'h00, 1, 1, "R10 count run");
        async_clear_cas();
        drv_cas(1, 1, 8'h00, 1, 1, "R4 after async clear");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule